// File: doc/BRIEF.md
# Two-Counter Performance Monitor

This block counts processor activity for profiling. It holds a free-running cycle counter and two event counters, each 32 bits wide. Every event counter picks one of up to sixteen single-cycle event pulses from the core through an 8-bit event code. When a counter wraps, its overflow flag sets. The flag can drive a level interrupt toward the core.

Software reaches the block through a single-cycle register port, which has a 2-bit address, a write strobe, write data and combinational read data. One control word holds the following fields:

- the global run bit;
- the two write-one reset actions;
- the cycle-divide option;
- the three interrupt enables;
- the three sticky overflow flags;
- both event selectors.

The other three addresses give direct read and write access to the counters. The bit positions in the control word are fixed because driver code decodes them.

Top module: `evt_perf_monitor`

## Requirements
- R1: After a synchronous active-low reset, all three counters read 0 and `irq_o` is low. The control word reads 0x0FFF_F000, which means both selectors hold code 0xFF and every other field is 0.
- R2: While control bit 0 (run) is clear, no counter changes except through a direct write or a reset action.
- R3: While run is set, event counter n adds 1 in each cycle where the event input indexed by its selector is high. Selector 0 sits in bits 19:12 and selector 1 in bits 27:20. A code of 0xFF, or any code of 16 or more, never counts.
- R4: While run is set and bit 3 is clear, the cycle counter adds 1 every cycle. While run and bit 3 are both set, it adds 1 on every 64th such cycle. The divide phase restarts whenever the cycle counter is reset through bit 2.
- R5: A control write with bit 1 set zeroes both event counters, and a control write with bit 2 set zeroes the cycle counter. Either reset overrides an increment in the same cycle. Bits 1 and 2 always read as 0.
- R6: When a counter steps from 0xFFFF_FFFF to 0, its overflow flag sets. The flag for event counter 0 is bit 8, for event counter 1 is bit 9, and for the cycle counter is bit 10.
- R7: A control write with a 1 in a flag bit clears that flag, and a 0 leaves it unchanged. An overflow in the same cycle as the clearing write leaves the flag set.
- R8: `irq_o` is high exactly when some flag is set together with its enable. The enable for event counter 0 is bit 4, for event counter 1 is bit 5, and for the cycle counter is bit 6.
- R9: Control bits 7, 11 and 31:28 read as 0 whatever was written to them.
- R10: The address map is 0 for control, 1 for the cycle counter, 2 for event counter 0 and 3 for event counter 1. A counter write loads the value, and the load takes priority over an increment in the same cycle.
- R11: A new selector, run or divide value takes effect from the cycle after the control write that carries it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| evt_i | input | 16 | Event pulses from the core, indexed by event code |
| irq_o | output | 1 | Level interrupt |

## Verification
Two collisions share a single cycle: a counter wrap landing in the same cycle as a control write that clears that counter's flag, and an event pulse landing in the same cycle as a counter reset or direct load. The bench provokes the first by preloading event counter 0 to 0xFFFF_FFFF and then issuing the clearing write while the selected event pulses, and it expects the flag to remain set. It provokes the second by pulsing the selected event during the reset write and during the load, and it expects 0 and the loaded value respectively. A behavioural model then repeats both collisions many times under random traffic biased toward counters near the wrap point.

// File: rtl/pmu_pkg.sv
// Shared constants for the performance monitor: control-word bit positions,
// counter indices and register addresses. Positions are fixed by software.
package pmu_pkg;
    localparam int CTL_RUN     = 0;
    localparam int CTL_EVCLR   = 1;
    localparam int CTL_CYCLR   = 2;
    localparam int CTL_DIV     = 3;
    localparam int CTL_IE_LO   = 4;
    localparam int CTL_FLAG_LO = 8;
    localparam int CTL_SEL0_LO = 12;
    localparam int CTL_SEL1_LO = 20;
    localparam int SEL_W       = 8;
    localparam int NUM_CNT     = 3;   // index 0,1 = event counters, 2 = cycle counter
    localparam int IDX_CYC     = 2;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_CYC  = 2'd1,
        REG_EV0  = 2'd2,
        REG_EV1  = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/pmu_counter.sv
// Loadable wrapping counter. Priority: load, then clear, then increment.
// Assumes load and clear are single-cycle strobes. wrap pulses when an
// increment takes the all-ones value to zero.
module pmu_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count,
    output logic         wrap
);
    // Wrap only when the increment actually applies.
    assign wrap = inc && !load && !clr && (&count);

    // Counter state update with fixed priority.
    always_ff @(posedge clk) begin
        if (!rst_n)     count <= '0;
        else if (load)  count <= load_val;
        else if (clr)   count <= '0;
        else if (inc)   count <= count + 1'b1;
    end
endmodule

// File: rtl/pmu_prescaler.sv
// Divide-by-RATIO tick generator for the cycle counter. It advances only
// while adv is high and restarts its phase on clr.
module pmu_prescaler #(
    parameter int RATIO = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic clr,
    output logic tick
);
    localparam int PW = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [PW-1:0] LAST = PW'(RATIO - 1);

    logic [PW-1:0] phase_q;

    // Tick on the last phase of an advancing cycle.
    assign tick = adv && (phase_q == LAST);

    // Phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n)    phase_q <= '0;
        else if (clr)  phase_q <= '0;
        else if (adv)  phase_q <= tick ? '0 : phase_q + 1'b1;
    end
endmodule

// File: rtl/pmu_ctrl_reg.sv
// Control word: run, divide, interrupt enables, event selectors, sticky
// overflow flags (write-one-to-clear, new overflow wins) and the two
// write-one reset strobes. Reserved bits are never stored.
module pmu_ctrl_reg
    import pmu_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [31:0]                   wr_data,
    input  logic [NUM_CNT-1:0]            wrap,
    output logic                          run,
    output logic                          div,
    output logic [NUM_CNT-1:0]            ie,
    output logic [NUM_CNT-1:0]            flag,
    output logic [1:0][SEL_W-1:0]         sel,
    output logic                          evt_clr,
    output logic                          cyc_clr,
    output logic [31:0]                   ctrl_rd
);
    logic [NUM_CNT-1:0] w1c;
    logic               unused_rsvd;

    assign unused_rsvd = ^{wr_data[7], wr_data[11], wr_data[31:28]};
    assign evt_clr = wr_en && wr_data[CTL_EVCLR];
    assign cyc_clr = wr_en && wr_data[CTL_CYCLR];
    assign w1c     = wr_en ? wr_data[CTL_FLAG_LO +: NUM_CNT] : '0;

    // Plain configuration fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
            div <= 1'b0;
            ie  <= '0;
            sel <= {2{{SEL_W{1'b1}}}};
        end else if (wr_en) begin
            run    <= wr_data[CTL_RUN];
            div    <= wr_data[CTL_DIV];
            ie     <= wr_data[CTL_IE_LO +: NUM_CNT];
            sel[0] <= wr_data[CTL_SEL0_LO +: SEL_W];
            sel[1] <= wr_data[CTL_SEL1_LO +: SEL_W];
        end
    end

    // Sticky flags: a same-cycle overflow beats the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flag <= '0;
        else        flag <= (flag & ~w1c) | wrap;
    end

    // Read view with reserved and strobe bits at zero.
    always_comb begin
        ctrl_rd                             = '0;
        ctrl_rd[CTL_RUN]                    = run;
        ctrl_rd[CTL_DIV]                    = div;
        ctrl_rd[CTL_IE_LO +: NUM_CNT]       = ie;
        ctrl_rd[CTL_FLAG_LO +: NUM_CNT]     = flag;
        ctrl_rd[CTL_SEL0_LO +: SEL_W]       = sel[0];
        ctrl_rd[CTL_SEL1_LO +: SEL_W]       = sel[1];
    end
endmodule

// File: rtl/evt_perf_monitor.sv
// Performance monitor top: two selectable event counters and a cycle
// counter behind a single-cycle register port, with one level interrupt.
// Assumes evt_i pulses are synchronous to clk.
module evt_perf_monitor
    import pmu_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int NUM_EVT   = 16,
    parameter int DIV_RATIO = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [1:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_EVT-1:0] evt_i,
    output logic               irq_o
);
    localparam int EVT_IDX_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

    logic                    run_w, div_w, evt_clr_w, cyc_clr_w, tick_w;
    logic [NUM_CNT-1:0]      ie_w, flag_w, wrap_w, inc_w;
    logic [1:0][SEL_W-1:0]   sel_w;
    logic [31:0]             ctrl_rd_w;
    logic [CNT_W-1:0]        cnt_w [NUM_CNT];

    pmu_ctrl_reg u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr_en(bus_we && (bus_addr == REG_CTRL)), .wr_data(bus_wdata),
        .wrap(wrap_w), .run(run_w), .div(div_w), .ie(ie_w), .flag(flag_w),
        .sel(sel_w), .evt_clr(evt_clr_w), .cyc_clr(cyc_clr_w), .ctrl_rd(ctrl_rd_w)
    );

    // Two event counters, each steered by its own selector.
    for (genvar i = 0; i < 2; i++) begin : g_evt
        localparam logic [1:0] MY_ADDR = 2'(int'(REG_EV0) + i);
        assign inc_w[i] = run_w && (sel_w[i] < SEL_W'(NUM_EVT))
                          && evt_i[sel_w[i][EVT_IDX_W-1:0]];
        pmu_counter #(.W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n),
            .load(bus_we && (bus_addr == MY_ADDR)), .load_val(bus_wdata[CNT_W-1:0]),
            .clr(evt_clr_w), .inc(inc_w[i]), .count(cnt_w[i]), .wrap(wrap_w[i])
        );
    end

    pmu_prescaler #(.RATIO(DIV_RATIO)) u_pre (
        .clk(clk), .rst_n(rst_n), .adv(run_w && div_w), .clr(cyc_clr_w), .tick(tick_w)
    );

    assign inc_w[IDX_CYC] = run_w && (!div_w || tick_w);

    pmu_counter #(.W(CNT_W)) u_cyc (
        .clk(clk), .rst_n(rst_n),
        .load(bus_we && (bus_addr == REG_CYC)), .load_val(bus_wdata[CNT_W-1:0]),
        .clr(cyc_clr_w), .inc(inc_w[IDX_CYC]), .count(cnt_w[IDX_CYC]), .wrap(wrap_w[IDX_CYC])
    );

    // Register read multiplexer.
    always_comb begin
        unique case (bus_addr)
            REG_CTRL: bus_rdata = ctrl_rd_w;
            REG_CYC:  bus_rdata = 32'(cnt_w[IDX_CYC]);
            REG_EV0:  bus_rdata = 32'(cnt_w[0]);
            default:  bus_rdata = 32'(cnt_w[1]);
        endcase
    end

    assign irq_o = |(flag_w & ie_w);
endmodule

// File: rtl/pmu_checker.sv
// Protocol and state properties for evt_perf_monitor, attached by bind.
module pmu_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_we,
    input logic [1:0]       bus_addr,
    input logic [31:0]      bus_wdata,
    input logic [31:0]      bus_rdata,
    input logic             irq_o,
    input logic             run,
    input logic             div,
    input logic [2:0]       flag,
    input logic [CNT_W-1:0] cyc_cnt,
    input logic [CNT_W-1:0] ev0_cnt
);
    p_halt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !bus_we) |=> ($stable(cyc_cnt) && $stable(ev0_cnt)));

    p_cyc_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 2'd0 && bus_wdata[2]) |=> (cyc_cnt == '0));

    p_wrap_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !div && !bus_we && (&cyc_cnt)) |=> flag[2]);

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag[2] && !(bus_we && bus_addr == 2'd0 && bus_wdata[10])) |=> flag[2]);

    p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag == 3'b000) |-> !irq_o);

    p_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd0) |-> (bus_rdata[7] == 1'b0 && bus_rdata[11] == 1'b0
                                && bus_rdata[31:28] == 4'h0 && bus_rdata[2:1] == 2'b00));

    p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 2'd1) |=> (cyc_cnt == $past(bus_wdata[CNT_W-1:0])));
endmodule

bind evt_perf_monitor pmu_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
    .run(run_w), .div(div_w), .flag(flag_w),
    .cyc_cnt(cnt_w[2]), .ev0_cnt(cnt_w[0])
);

// File: tb/evt_perf_monitor_bench.sv
`timescale 1ns/1ps
module evt_perf_monitor_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic [15:0] evt_i = 16'd0;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    evt_perf_monitor u_evt_perf_monitor (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_i(evt_i), .irq_o(irq_o)
    );

    // ---------------- behavioural reference model ----------------
    bit          m_run, m_div;
    bit [2:0]    m_ie, m_flag, m_ovf, m_inc;
    bit [7:0]    m_sel [2];
    bit [31:0]   m_cnt [3];
    int          m_pre;
    bit          m_tick;

    function automatic bit [31:0] mread(input bit [1:0] a);
        bit [31:0] v;
        case (a)
            2'd0: begin
                v = 32'd0;
                v[0] = m_run; v[3] = m_div; v[6:4] = m_ie; v[10:8] = m_flag;
                v[19:12] = m_sel[0]; v[27:20] = m_sel[1];
            end
            2'd1: v = m_cnt[2];
            2'd2: v = m_cnt[0];
            default: v = m_cnt[1];
        endcase
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_div = 0; m_ie = 0; m_flag = 0; m_pre = 0;
            m_sel[0] = 8'hFF; m_sel[1] = 8'hFF;
            for (int k = 0; k < 3; k++) m_cnt[k] = 0;
        end else begin
            bit ctl_wr;
            ctl_wr = bus_we && bus_addr == 2'd0;
            for (int e = 0; e < 2; e++)
                m_inc[e] = m_run && (m_sel[e] < 16) && evt_i[m_sel[e]];
            m_tick = m_run && m_div && (m_pre == 63);
            m_inc[2] = m_run && (!m_div || m_tick);
            if (ctl_wr && bus_wdata[2]) m_pre = 0;
            else if (m_run && m_div) m_pre = m_tick ? 0 : m_pre + 1;
            m_ovf = 0;
            for (int k = 0; k < 3; k++) begin
                int a;
                bit clr;
                a = (k == 2) ? 1 : k + 2;
                clr = ctl_wr && ((k == 2) ? bus_wdata[2] : bus_wdata[1]);
                if (bus_we && bus_addr == a[1:0]) m_cnt[k] = bus_wdata;
                else if (clr) m_cnt[k] = 0;
                else if (m_inc[k]) begin
                    if (m_cnt[k] == 32'hFFFF_FFFF) m_ovf[k] = 1;
                    m_cnt[k] = m_cnt[k] + 1;
                end
            end
            m_flag = (m_flag & ~(ctl_wr ? bus_wdata[10:8] : 3'b000)) | m_ovf;
            if (ctl_wr) begin
                m_run = bus_wdata[0]; m_div = bus_wdata[3]; m_ie = bus_wdata[6:4];
                m_sel[0] = bus_wdata[19:12]; m_sel[1] = bus_wdata[27:20];
            end
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input string tag, input bit [31:0] act, input bit [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Every-clock comparison of the visible outputs against the model.
    task automatic compare_now();
        chk("R10 read data", bus_rdata, mread(bus_addr));
        chk("R8 irq level", {31'd0, irq_o}, {31'd0, |(m_flag & m_ie)});
    endtask

    task automatic step(input bit we, input bit [1:0] a, input bit [31:0] d, input bit [15:0] ev);
        @(negedge clk);
        if (rst_n) compare_now();
        bus_we = we; bus_addr = a; bus_wdata = d; evt_i = ev;
    endtask

    task automatic rd(input bit [1:0] a, input bit [31:0] exp, input string tag);
        step(1'b0, a, 32'd0, 16'd0);
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic rdm(input bit [1:0] a, input string tag);
        step(1'b0, a, 32'd0, 16'd0);
        #1;
        chk(tag, bus_rdata, mread(a));
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1 reset state
        rd(2'd0, 32'h0FFF_F000, "R1 ctrl");
        rd(2'd1, 32'd0, "R1 cycle");
        rd(2'd2, 32'd0, "R1 ev0");
        rd(2'd3, 32'd0, "R1 ev1");
        chk("R1 irq", {31'd0, irq_o}, 32'd0);
        // R2 halted: selector set, run clear
        step(1'b1, 2'd0, 32'h0FF0_2000, 16'd0);
        for (int i = 0; i < 5; i++) step(1'b0, 2'd2, 32'd0, 16'hFFFF);
        rd(2'd2, 32'd0, "R2 ev0 halted");
        rd(2'd1, 32'd0, "R2 cycle halted");
        // R3 counting, code >= 16 ignored (bit 4 pulses too)
        step(1'b1, 2'd0, 32'h0140_3001, 16'd0);
        for (int i = 0; i < 5; i++) step(1'b0, 2'd2, 32'd0, 16'h0018);
        step(1'b1, 2'd0, 32'h0140_3000, 16'd0);
        rd(2'd2, 32'd5, "R3 ev0 count");
        rd(2'd3, 32'd0, "R3 ev1 code 0x14");
        // R4 divided cycle counting
        step(1'b1, 2'd0, 32'h0140_300D, 16'd0);
        for (int i = 0; i < 130; i++) step(1'b0, 2'(i), 32'd0, 16'd0);
        step(1'b1, 2'd0, 32'h0140_3008, 16'd0);
        rd(2'd1, 32'd2, "R4 divide by 64");
        // R5 reset beats increment
        step(1'b1, 2'd0, 32'h0140_3001, 16'd0);
        step(1'b0, 2'd2, 32'd0, 16'h0008);
        step(1'b1, 2'd0, 32'h0140_3003, 16'h0008);
        rd(2'd2, 32'd0, "R5 evt reset");
        rdm(2'd1, "R4 undivided cycle");
        // R10 load beats increment, R6 wrap flag, R8 irq
        step(1'b1, 2'd0, 32'h0140_3011, 16'd0);
        step(1'b1, 2'd2, 32'hFFFF_FFFE, 16'h0008);
        rd(2'd2, 32'hFFFF_FFFE, "R10 load priority");
        step(1'b0, 2'd2, 32'd0, 16'h0008);
        step(1'b0, 2'd2, 32'd0, 16'h0008);
        rd(2'd0, 32'h0140_3111, "R6 flag bit 8");
        chk("R8 irq raised", {31'd0, irq_o}, 32'd1);
        // R7 clear, then clear colliding with new wrap
        step(1'b1, 2'd0, 32'h0140_3111, 16'd0);
        rd(2'd0, 32'h0140_3011, "R7 flag cleared");
        chk("R7 irq dropped", {31'd0, irq_o}, 32'd0);
        step(1'b1, 2'd2, 32'hFFFF_FFFF, 16'd0);
        step(1'b0, 2'd2, 32'd0, 16'h0008);
        step(1'b1, 2'd2, 32'hFFFF_FFFF, 16'd0);
        step(1'b1, 2'd0, 32'h0140_3111, 16'h0008);
        rd(2'd0, 32'h0140_3111, "R7 overflow wins");
        // R8 enable removed, flag kept
        step(1'b1, 2'd0, 32'h0140_3001, 16'd0);
        rd(2'd0, 32'h0140_3101, "R8 flag kept");
        chk("R8 irq masked", {31'd0, irq_o}, 32'd0);
        // R9 reserved bits
        step(1'b1, 2'd0, 32'hFFFF_FFFF, 16'd0);
        rd(2'd0, 32'h0FFF_F079, "R9 reserved zero");
        // R11 new selectors take effect next cycle
        step(1'b1, 2'd0, 32'h0050_5001, 16'h0020);
        for (int i = 0; i < 3; i++) step(1'b0, 2'd3, 32'd0, 16'h0020);
        rd(2'd2, 32'd3, "R11 selector 0");
        rd(2'd3, 32'd3, "R11 selector 1");
        // Random traffic, compared every clock
        for (int i = 0; i < 600; i++) begin
            bit [1:0]  a;
            bit [31:0] d;
            a = 2'($urandom);
            d = (a == 2'd0) ? ($urandom | 32'd1) & 32'hF0FF_FFFF
                            : (32'hFFFF_FFF0 | ($urandom % 16));
            if (a == 2'd0 && ($urandom % 2)) d[19:12] = 8'($urandom % 20);
            step(($urandom % 5) == 0, a, d, 16'($urandom));
        end
        step(1'b0, 2'd0, 32'd0, 16'd0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule